// File: doc/BRIEF.md
# Serial Character Transmitter

This block sends characters over an asynchronous serial line. The host writes a character of 5 to 9 bits into a one-entry holding register. The block moves that character into a frame shifter and sends it out on `tx_o`. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit stays on the line until the next pulse on the baud tick input, so the baud-rate generator sits outside the block.

Clearing the enable is deferred. A frame already on the line runs to its end, and the block gives up the pin only after that. A pin-ownership output tells the pad logic whether the pin carries the serial function or is free for general-purpose use. A completion flag marks the moment the line goes idle. It feeds an interrupt request that is gated by a local enable and a global enable. The flag clears on an interrupt acknowledge or on a software clear strobe.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset `tx_o` is 1, `done_o` is 0, and `pin_own_o` is 0 while `tx_en_i` is 0. Whenever the pin is released, `tx_o` is 1.
- R2: A frame is one 0 start bit, then the data bits LSB first, then the stop bits at 1. The character length comes from `char_len_i`: codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 give 9 bits. The length, parity and stop settings are taken when the frame is loaded.
- R3: When `par_en_i` is 1, one parity bit goes after the last data bit and before the first stop bit. With `par_odd_i` = 0 it is the XOR of the sent data bits; with `par_odd_i` = 1 it is the inverse of that XOR.
- R4: `two_stop_i` = 0 gives one stop bit and `two_stop_i` = 1 gives two.
- R5: While a frame is in flight, `tx_o` changes only at a clock edge where `baud_tick_i` is 1. Each bit lasts for one tick interval.
- R6: A write while the holding register is empty is accepted. A write while it is full is ignored. A held character starts in the cycle the previous frame ends, with no idle bit between the two frames.
- R7: Clearing `tx_en_i` during a frame lets that frame finish. `pin_own_o` stays 1 until the frame ends and is 0 afterwards. A character held while disabled is not sent until `tx_en_i` returns to 1.
- R8: `done_o` is set at the clock edge that ends the last stop bit, if no further frame starts at that edge.
- R9: `done_o` clears at the edge after `irq_ack_i` or `done_clr_i` is 1. If setting and clearing fall on the same edge, setting wins.
- R10: `irq_o` is 1 exactly when `done_o`, `done_ie_i` and `global_ie_i` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable (deferred off) |
| char_len_i | input | 3 | Character length code |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| two_stop_i | input | 1 | 1 = two stop bits |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| wr_i | input | 1 | Character write strobe |
| wr_data_i | input | 9 | Character to send, LSB first |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| done_clr_i | input | 1 | Software clear of the flag |
| done_ie_i | input | 1 | Completion interrupt enable |
| global_ie_i | input | 1 | Global interrupt enable |
| tx_o | output | 1 | Serial line, idles high |
| pin_own_o | output | 1 | 1 = pin driven by the transmitter |
| done_o | output | 1 | Transmit-complete flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The frame format is tried with several characters: an 8-bit character with no parity, a 7-bit character with even parity and two stop bits, a saturated length code with odd parity over nine ones, and a 5-bit character. Together these separate the bit order, the data mask, the parity polarity and the stop count. Three writes in quick succession show whether the second frame follows the first with no gap and whether the third write is dropped. A disable in the middle of a frame, a write while disabled and a later re-enable separate deferred shutdown from an immediate cut. The flag is cleared by acknowledge, by software, and by a clear held across the edge that sets it, which shows the set priority.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take_i) full_q <= 1'b0;
      // write while full is dropped; full_q is the pre-edge value
      if (wr_i && !full_q) begin
        data_q <= wr_data_i;
        full_q <= 1'b1;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned MIN_W   = 5,
  parameter int unsigned LEN_W   = 3,
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned CNT_W   = 4
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [LEN_W-1:0]   len_code_i,
  input  frame_cfg_t         cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  localparam int unsigned SPAN = DATA_W - MIN_W;
  localparam logic [LEN_W-1:0] MAX_CODE = LEN_W'(SPAN);

  logic [CNT_W-1:0]   ndata;
  logic [DATA_W-1:0]  mask;
  logic [FRAME_W-1:0] dext;
  logic               par_bit;

  assign ndata = (len_code_i > MAX_CODE) ? CNT_W'(DATA_W)
                                         : CNT_W'(MIN_W) + CNT_W'(len_code_i);

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign mask[g] = (CNT_W'(g) < ndata);
    end
  endgenerate

  assign par_bit = (^(data_i & mask)) ^ cfg_i.par_odd;
  assign dext    = {{(FRAME_W-DATA_W){1'b1}}, data_i};

  // bit 0 = start, then data, then parity, rest stays high (stop)
  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int p = 1; p < FRAME_W; p++) begin
      if (CNT_W'(p) <= ndata)
        frame_o[p] = dext[p-1];
      else if (cfg_i.par_en && (CNT_W'(p) == ndata + CNT_W'(1)))
        frame_o[p] = par_bit;
    end
  end

  assign nbits_o = CNT_W'(2) + ndata + CNT_W'(cfg_i.par_en) + CNT_W'(cfg_i.two_stop);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_ok_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  output logic               take_o,
  output logic               done_set_o,
  output logic               busy_o,
  output logic               line_o
);
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               last_bit;

  assign last_bit   = busy_q && tick_i && (cnt_q == CNT_W'(1));
  assign take_o     = start_ok_i && (!busy_q || last_bit);
  assign done_set_o = last_bit && !start_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (take_o) begin
      shift_q <= frame_i;
      cnt_q   <= nbits_i;
      busy_q  <= 1'b1;
    end else if (last_bit) begin
      shift_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (busy_q && tick_i) begin
      shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? shift_q[0] : 1'b1;
endmodule

// File: rtl/tx_done_flag.sv
module tx_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_q <= 1'b0;
    else if (set_i)          flag_q <= 1'b1;
    else if (ack_i || clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
  import serial_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned MIN_W  = 5,
  parameter int unsigned LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              baud_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              irq_ack_i,
  input  logic              done_clr_i,
  input  logic              done_ie_i,
  input  logic              global_ie_i,
  output logic              tx_o,
  output logic              pin_own_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic               take;
  logic               busy;
  logic               done_set;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  frame_cfg_t         cfg;

  assign cfg = '{par_en: par_en_i, par_odd: par_odd_i, two_stop: two_stop_i};

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .take_i(take), .full_o(hold_full), .data_o(hold_data)
  );

  tx_frame_build #(
    .DATA_W(DATA_W), .MIN_W(MIN_W), .LEN_W(LEN_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_build (
    .data_i(hold_data), .len_code_i(char_len_i), .cfg_i(cfg),
    .frame_o(frame), .nbits_o(nbits)
  );

  tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(baud_tick_i),
    .start_ok_i(tx_en_i && hold_full), .frame_i(frame), .nbits_i(nbits),
    .take_o(take), .done_set_o(done_set), .busy_o(busy), .line_o(tx_o)
  );

  tx_done_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(done_set), .ack_i(irq_ack_i),
    .clr_i(done_clr_i), .flag_o(done_o)
  );

  // pin stays owned while a frame drains after the enable drops
  assign pin_own_o = tx_en_i || busy;
  assign irq_o     = done_o && done_ie_i && global_ie_i;
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk #(
  parameter int unsigned DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_i,
  input logic              baud_tick_i,
  input logic              irq_ack_i,
  input logic              done_clr_i,
  input logic              tx_o,
  input logic              pin_own_o,
  input logic              done_o,
  input logic              irq_o,
  input logic              busy_i,
  input logic              take_i,
  input logic              done_set_i,
  input logic              hold_full_i,
  input logic [DATA_W-1:0] hold_data_i
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_own_o |-> tx_o);

  assert_tick_pace_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !baud_tick_i && !take_i) |=> $stable(tx_o));

  assert_hold_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_i && !take_i) |=> (hold_full_i && $stable(hold_data_i)));

  assert_defer_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tx_en_i) |-> pin_own_o);

  assert_done_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_i) && !busy_i));

  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_ack_i || done_clr_i) && !done_set_i) |=> !done_o);

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
endmodule

bind serial_tx_unit serial_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .baud_tick_i(baud_tick_i),
  .irq_ack_i(irq_ack_i), .done_clr_i(done_clr_i), .tx_o(tx_o),
  .pin_own_o(pin_own_o), .done_o(done_o), .irq_o(irq_o), .busy_i(busy),
  .take_i(take), .done_set_i(done_set), .hold_full_i(hold_full),
  .hold_data_i(hold_data)
);

// File: tb/tb_serial_tx_unit.sv
`timescale 1ns/1ps
module tb_serial_tx_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [2:0] len_code = 3'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] wr_data = '0;
  logic       ack = 1'b0, clr = 1'b0, ie = 1'b0, gie = 1'b0;
  logic       tx, pin_own, done, irq;

  int errors = 0, checks = 0, cycles = 0;
  int bcnt = 0;

  bit       m_busy = 0, m_done = 0;
  bit       m_bits[$];
  bit [8:0] m_hold[$];
  bit       cap[$], expq[$];
  bit       cap_on = 0;

  always #10 clk = ~clk;

  serial_tx_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .char_len_i(len_code),
    .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .baud_tick_i(baud_tick), .wr_i(wr), .wr_data_i(wr_data), .irq_ack_i(ack),
    .done_clr_i(clr), .done_ie_i(ie), .global_ie_i(gie), .tx_o(tx),
    .pin_own_o(pin_own), .done_o(done), .irq_o(irq)
  );

  function automatic void push_frame(ref bit q[$], input bit [8:0] d, input bit [2:0] lc,
                                     input bit pe, input bit po, input bit ts);
    int n;
    bit par;
    n = (lc > 3'd4) ? 9 : int'(lc) + 5;
    par = 1'b0;
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(d[i]);
      par ^= d[i];
    end
    if (pe) q.push_back(par ^ po);
    q.push_back(1'b1);
    if (ts) q.push_back(1'b1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_bits.delete(); m_hold.delete();
    end else begin
      int  held;
      bit  setd;
      bit  start;
      held  = m_hold.size();
      setd  = 0;
      start = 0;
      if (m_busy && baud_tick) begin
        void'(m_bits.pop_front());
        if (m_bits.size() == 0) begin
          if (tx_en && m_hold.size() != 0) start = 1;
          else begin m_busy = 0; setd = 1; end
        end
      end else if (!m_busy && tx_en && m_hold.size() != 0) start = 1;
      if (start) begin
        push_frame(m_bits, m_hold.pop_front(), len_code, par_en, par_odd, two_stop);
        m_busy = 1;
      end
      if (wr && held == 0) m_hold.push_back(wr_data);
      if (setd) m_done = 1;
      else if (ack || clr) m_done = 0;
    end
  end

  always @(negedge clk) begin
    baud_tick = (bcnt == 3);
    bcnt = (bcnt + 1) % 4;
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit e_tx;
      e_tx = m_busy ? m_bits[0] : 1'b1;
      chk(tx == e_tx, "R2 tx_o per-cycle", int'(tx), int'(e_tx));
      chk(pin_own == (tx_en | m_busy), "R7 pin_own_o per-cycle", int'(pin_own), int'(tx_en | m_busy));
      chk(done == m_done, "R8 done_o per-cycle", int'(done), int'(m_done));
      chk(irq == (m_done & ie & gie), "R10 irq_o per-cycle", int'(irq), int'(m_done & ie & gie));
      if (cap_on && baud_tick && m_busy) cap.push_back(tx);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<60000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input bit [8:0] d);
    @(negedge clk); wr = 1'b1; wr_data = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while ((m_busy || m_hold.size() != 0) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    step(2);
  endtask

  task automatic check_frames(input string tag);
    bit [31:0] av, ev;
    bit ok;
    av = '0; ev = '0;
    foreach (cap[i])  if (i < 32) av[i] = cap[i];
    foreach (expq[i]) if (i < 32) ev[i] = expq[i];
    ok = (cap.size() == expq.size()) && (av == ev);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d bits 0x%0h expected=%0d bits 0x%0h",
               tag, cap.size(), av, expq.size(), ev);
    end
    cap.delete(); expq.delete();
  endtask

  task automatic send_one(input bit [8:0] d, input string tag);
    cap.delete(); expq.delete(); cap_on = 1;
    push_frame(expq, d, len_code, par_en, par_odd, two_stop);
    write(d);
    wait_idle();
    cap_on = 0;
    check_frames(tag);
  endtask

  initial begin
    bit saw;
    step(3);
    #2 chk(tx == 1'b1, "R1 tx_o in reset", int'(tx), 1);
    chk(done == 1'b0, "R1 done_o in reset", int'(done), 0);
    @(negedge clk); rst_n = 1'b1;
    step(2);
    #2 chk(tx == 1'b1 && pin_own == 1'b0, "R1 idle after reset", int'({tx, pin_own}), 2);

    // R2: 8 data bits, no parity, one stop
    @(negedge clk); tx_en = 1'b1;
    send_one(9'h0A5, "R2 8N1 frame 0xA5");
    #2 chk(done == 1'b1, "R8 flag after frame", int'(done), 1);
    chk(irq == 1'b0, "R10 irq masked by local enable", int'(irq), 0);

    // R3/R4: 7 bits even parity, two stops
    @(negedge clk); len_code = 3'd2; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
    send_one(9'h035, "R3 R4 7E2 frame 0x35");

    // R3/R2: saturated code 6 -> 9 bits, odd parity over nine ones
    @(negedge clk); len_code = 3'd6; par_odd = 1'b1; two_stop = 1'b0;
    send_one(9'h1FF, "R3 9O1 saturated code frame 0x1FF");

    // R2: 5 bits
    @(negedge clk); len_code = 3'd0; par_en = 1'b0;
    send_one(9'h013, "R2 5N1 frame 0x13");

    // R6: back-to-back, third write dropped
    @(negedge clk); len_code = 3'd3;
    cap.delete(); expq.delete(); cap_on = 1;
    push_frame(expq, 9'h03C, 3'd3, 1'b0, 1'b0, 1'b0);
    push_frame(expq, 9'h0C3, 3'd3, 1'b0, 1'b0, 1'b0);
    write(9'h03C);
    step(3);
    write(9'h0C3);
    write(9'h055);
    wait_idle();
    cap_on = 0;
    check_frames("R6 two frames, write while full dropped");

    // R7: disable mid-frame
    write(9'h081);
    step(10);
    @(negedge clk); tx_en = 1'b0;
    step(2);
    #2 chk(pin_own == 1'b1, "R7 pin held during drain", int'(pin_own), 1);
    wait_idle();
    #2 chk(pin_own == 1'b0 && tx == 1'b1, "R7 pin released after frame", int'({pin_own, tx}), 1);
    cap.delete(); expq.delete(); cap_on = 1;
    push_frame(expq, 9'h042, 3'd3, 1'b0, 1'b0, 1'b0);
    write(9'h042);
    step(40);
    #2 chk(tx == 1'b1 && pin_own == 1'b0, "R7 held char not sent while disabled", int'({tx, pin_own}), 2);
    @(negedge clk); tx_en = 1'b1;
    wait_idle();
    cap_on = 0;
    check_frames("R7 held char sent after re-enable");

    // R10/R9: gating and clears
    @(negedge clk); ie = 1'b1; gie = 1'b0;
    #2 chk(irq == 1'b0, "R10 irq masked by global enable", int'(irq), 0);
    @(negedge clk); gie = 1'b1;
    #2 chk(irq == 1'b1, "R10 irq with all enables", int'(irq), 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #2 chk(done == 1'b0 && irq == 1'b0, "R9 ack clears flag", int'({done, irq}), 0);
    write(9'h0F0);
    wait_idle();
    #2 chk(done == 1'b1, "R8 flag set again", int'(done), 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk);
    #2 chk(done == 1'b0, "R9 software clear", int'(done), 0);

    // R9: clear held across the setting edge, set wins for one cycle
    saw = 0;
    write(9'h00F);
    while (m_busy || m_hold.size() != 0) begin
      @(negedge clk); #2 if (done) saw = 1;
    end
    step(2);
    #2 chk(saw == 1'b1, "R9 set wins over clear", int'(saw), 1);
    chk(done == 1'b0, "R9 clear after set", int'(done), 0);
    @(negedge clk); clr = 1'b0;
    step(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule